// File: doc/BRIEF.md
# Burst Soft-Start Duty Profile Sequencer

This block sits between a lamp controller's duty-cycle loop and its gate driver. Dimming works in bursts: a slow dimming waveform switches the lamp on and off, and each high period is one burst. Switching the full duty on at once can make the transformer audible. So at the start of every burst the block shapes the duty it passes to the driver. For the first sixteen lamp-frequency cycles it outputs a fraction of the present nominal duty. After that it passes the nominal duty through unchanged.

The shape of the ramp is programmable. Four 8-bit profile registers hold eight 4-bit codes. Each code selects a fraction in eighths and applies to two lamp cycles. Every fraction is taken from the nominal duty of the current moment, so a change in the loop's command shows at once, even during the ramp. The burst enable, the lamp-cycle strobe and the duty word are plain level and pulse signals. They are sampled every clock and have no handshake, because the lamp loop cannot be stalled. The register port is a simple single-cycle write with a combinational read.

Top module: `ssp_softstart_seq`

## Requirements
- R1: After reset, the profile registers at addresses F0h, F1h, F2h and F3h read back 21h, 43h, 65h and 77h.
- R2: A write with `cfg_wr` high lands in the addressed profile register at the clock edge. Writes to any other address change nothing, and reads of any other address return 0.
- R3: While `burst_en` is low, `duty_out` is 0 and the lamp-cycle count is held at the first cycle.
- R4: In a burst, lamp cycle n (n = 1..16) runs from the (n-1)th `lamp_tick` after `burst_en` rose to the nth. Cycle n uses register F0h + (n-1)/4: bits 3:0 when (n-1) mod 4 is 0 or 1, and bits 7:4 otherwise.
- R5: Code c in 1..6 scales the duty to (c+1)/8. Code 0 gives 0 and code 7 gives the full duty.
- R6: Reserved codes 8h to Fh give the full duty.
- R7: Scaling by e eighths is done by shift-and-add. Bit 3 of e adds d, bit 2 adds d>>1, bit 1 adds d>>2 and bit 0 adds d>>3. Each shifted term truncates.
- R8: From the 16th `lamp_tick` of a burst until `burst_en` falls, `duty_out` equals `duty_in`.
- R9: If a burst ends before its 16th tick, the next burst starts again from lamp cycle 1.
- R10: The fraction applies to the present `duty_in`, so a change in `duty_in` shows in `duty_out` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_en | input | 1 | High during a dimming burst |
| lamp_tick | input | 1 | One-clock pulse at each lamp-cycle boundary |
| duty_in | input | DUTY_W | Nominal duty from the lamp loop |
| cfg_wr | input | 1 | Profile register write strobe |
| cfg_addr | input | ADDR_W | Profile register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| duty_out | output | DUTY_W | Duty sent to the gate driver |

## Verification
A wrong cycle count or a wrong nibble select shows at `duty_out` as the wrong fraction. It shows in the first lamp cycle whose code differs from the expected one, with no extra latency, because the output is combinational from the count and `duty_in`. A counter that fails to clear between bursts shows at the first cycle of the next burst. A counter that fails to saturate shows as a ramp restarting after the 16th tick. Register faults show at once on `cfg_rdata`, and on `duty_out` during the affected pair of cycles.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned SS_CYCLES = 16;
  localparam int unsigned PROF_REGS = SS_CYCLES / 4;
  localparam int unsigned CNT_W     = $clog2(SS_CYCLES + 1);

  // code -> multiplier in eighths; reserved codes mean full duty
  function automatic logic [3:0] code_to_eighths(input logic [3:0] code);
    if (code == 4'd0)       return 4'd0;
    else if (code >= 4'd7)  return 4'd8;
    else                    return code + 4'd1;
  endfunction

  // reset profile: nibbles 1..8 capped at 7
  function automatic logic [7:0] prof_default(input int unsigned idx);
    logic [3:0] lo, hi;
    lo = (2*idx + 1 > 7) ? 4'd7 : 4'(2*idx + 1);
    hi = (2*idx + 2 > 7) ? 4'd7 : 4'(2*idx + 2);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/ssp_profile_regs.sv
module ssp_profile_regs
  import ssp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [2:0]        pair_sel,
  output logic [3:0]        code
);
  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(PROF_REGS);

  logic [7:0]        prof [PROF_REGS];
  logic [ADDR_W-1:0] off;
  logic              hit;

  assign off = addr - BASE;
  assign hit = (addr >= BASE) && (off < NREG_A);

  for (genvar i = 0; i < PROF_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   prof[i] <= prof_default(i);
      else if (wr_en && hit && off == ADDR_W'(i))   prof[i] <= wdata;
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit && off == ADDR_W'(i)) |=> prof[i] == $past(wdata));
  end

  assign rdata = hit ? prof[off[1:0]] : 8'h00;
  assign code  = pair_sel[0] ? prof[pair_sel[2:1]][7:4] : prof[pair_sel[2:1]][3:0];
endmodule

// File: rtl/ssp_cycle_counter.sv
module ssp_cycle_counter
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       burst_en,
  input  logic       lamp_tick,
  output logic [2:0] pair_sel,
  output logic       ramp_active
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SS_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!burst_en)                cnt <= '0;
    else if (lamp_tick && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign ramp_active = (cnt != LAST);
  assign pair_sel    = cnt[3:1];

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |=> (ramp_active && pair_sel == 3'd0));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && lamp_tick && ramp_active) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/ssp_duty_scaler.sv
module ssp_duty_scaler
  import ssp_pkg::*;
#(
  parameter int unsigned DUTY_W = 10
) (
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [3:0]        code,
  output logic [DUTY_W-1:0] duty_scaled
);
  logic [3:0]      eighths;
  logic [DUTY_W:0] sum;

  always_comb begin
    eighths = code_to_eighths(code);
    sum = '0;
    if (eighths[3]) sum = sum + {1'b0, duty_in};
    if (eighths[2]) sum = sum + {1'b0, duty_in >> 1};
    if (eighths[1]) sum = sum + {1'b0, duty_in >> 2};
    if (eighths[0]) sum = sum + {1'b0, duty_in >> 3};
    duty_scaled = sum[DUTY_W-1:0];
  end
endmodule

// File: rtl/ssp_softstart_seq.sv
module ssp_softstart_seq
  import ssp_pkg::*;
#(
  parameter int unsigned DUTY_W = 10,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_en,
  input  logic              lamp_tick,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [DUTY_W-1:0] duty_out
);
  logic [2:0]        pair_sel;
  logic              ramp_active;
  logic [3:0]        code;
  logic [DUTY_W-1:0] duty_scaled;

  ssp_cycle_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .lamp_tick(lamp_tick),
    .pair_sel(pair_sel), .ramp_active(ramp_active)
  );

  ssp_profile_regs #(.ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .pair_sel(pair_sel), .code(code)
  );

  ssp_duty_scaler #(.DUTY_W(DUTY_W)) u_scale (
    .duty_in(duty_in), .code(code), .duty_scaled(duty_scaled)
  );

  always_comb begin
    if (!burst_en)        duty_out = '0;
    else if (ramp_active) duty_out = duty_scaled;
    else                  duty_out = duty_in;
  end

  a_r7_no_exceed: assert property (@(posedge clk) disable iff (!rst_n)
    duty_out <= duty_in);
  a_r8_stays_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(burst_en) && burst_en && !$past(ramp_active)) |-> duty_out == duty_in);
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_en) |-> duty_out == '0);
endmodule

// File: tb/tb_ssp_softstart_seq.sv
module tb_ssp_softstart_seq;
  localparam int DUTY_W = 10;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              burst_en = 0;
  logic              lamp_tick = 0;
  logic [DUTY_W-1:0] duty_in = '0;
  logic              cfg_wr = 0;
  logic [7:0]        cfg_addr = 8'h00;
  logic [7:0]        cfg_wdata = 8'h00;
  logic [7:0]        cfg_rdata;
  logic [DUTY_W-1:0] duty_out;

  always #2.5 clk = ~clk;

  ssp_softstart_seq dut (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .lamp_tick(lamp_tick),
    .duty_in(duty_in), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .duty_out(duty_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    q_exp[$];
  bit    q_rd[$];
  string q_tag[$];

  int m_idx = 0;
  int m_reg[4] = '{8'h21, 8'h43, 8'h65, 8'h77};

  function automatic int scale(input int d, input int c);
    int e, s;
    e = (c == 0) ? 0 : (c >= 7 ? 8 : c + 1);
    s = 0;
    if (e & 8) s += d;
    if (e & 4) s += d >> 1;
    if (e & 2) s += d >> 2;
    if (e & 1) s += d >> 3;
    return s;
  endfunction

  // one clock: drive at negedge, push expectations, advance model
  task automatic step(input bit b, input bit t, input int d,
                      input bit wr, input int a, input int wd,
                      input bit rd_chk, input string ctx);
    int code, exp;
    string tag;
    @(negedge clk);
    burst_en = b; lamp_tick = t; duty_in = DUTY_W'(d);
    cfg_wr = wr; cfg_addr = 8'(a); cfg_wdata = 8'(wd);
    if (!b) begin exp = 0; tag = "R3"; end
    else if (m_idx >= 16) begin exp = d; tag = "R8"; end
    else begin
      code = (m_idx[1]) ? (m_reg[m_idx >> 2] >> 4) & 15 : m_reg[m_idx >> 2] & 15;
      exp = scale(d, code);
      tag = (code >= 8) ? "R6" : "R4/R5/R7";
    end
    q_exp.push_back(exp); q_rd.push_back(0); q_tag.push_back({tag, " ", ctx});
    if (rd_chk) begin
      q_exp.push_back((a >= 'hF0 && a <= 'hF3) ? m_reg[a - 'hF0] : 0);
      q_rd.push_back(1); q_tag.push_back({"R1/R2 ", ctx});
    end
    if (wr && a >= 'hF0 && a <= 'hF3) m_reg[a - 'hF0] = wd & 255;
    if (!b) m_idx = 0;
    else if (t && m_idx < 16) m_idx++;
  endtask

  // monitor: pops expectations after inputs settle
  always @(negedge clk) begin
    #1;
    while (q_exp.size() > 0) begin
      int e; bit r; string g; int act;
      e = q_exp.pop_front(); r = q_rd.pop_front(); g = q_tag.pop_front();
      act = r ? int'(cfg_rdata) : int'(duty_out);
      checks++;
      if (act != e) begin
        errors++;
        $display("FAIL %s: actual %0d expected %0d", g, act, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset defaults, R3 idle output
    for (int a = 'hF0; a <= 'hF3; a++) step(0, 0, 300, 0, a, 0, 1, "R1 defaults");
    // default 12-cycle ramp, tick every clock; R8 after 16 ticks
    for (int i = 0; i < 20; i++) step(1, 1, 800, 0, 0, 0, 0, "default ramp");
    step(0, 0, 500, 0, 0, 0, 0, "R3 burst off");
    step(0, 1, 500, 0, 0, 0, 0, "R3 tick while off");
    // R2 writes: reserved codes in F0, codes 0..5 elsewhere, stray address
    step(0, 0, 0, 1, 'hF0, 'hF8, 0, "R6 setup");
    step(0, 0, 0, 1, 'hF1, 'h10, 0, "R5 setup");
    step(0, 0, 0, 1, 'hF2, 'h32, 0, "R5 setup");
    step(0, 0, 0, 1, 'hF3, 'h54, 0, "R5 setup");
    step(0, 0, 0, 1, 'hF4, 'h12, 1, "R2 stray write");
    step(0, 0, 0, 0, 'hF4, 0, 1, "R2 stray read");
    step(0, 0, 0, 0, 'hEF, 0, 1, "R2 below base");
    for (int a = 'hF0; a <= 'hF3; a++) step(0, 0, 0, 0, a, 0, 1, "R2 readback");
    // ramp with tick every other clock, duty changing (R10)
    for (int i = 0; i < 40; i++)
      step(1, i[0], 1000 - 7 * i, 0, 0, 0, 0, "R10 varying duty");
    step(0, 0, 0, 1, 'hF0, 'h76, 0, "R6 setup");
    step(0, 0, 0, 1, 'hF1, 'h00, 0, "R5 setup");
    // R9 abort after 5 ticks and restart
    for (int i = 0; i < 5; i++) step(1, 1, 999, 0, 0, 0, 0, "R9 first burst");
    step(0, 0, 999, 0, 0, 0, 0, "R9 gap");
    step(0, 0, 999, 0, 0, 0, 0, "R9 gap");
    for (int i = 0; i < 18; i++) step(1, 1, 999, 0, 0, 0, 0, "R9 restart");
    // full-scale duty, all four registers at 77h: no ramp
    for (int a = 'hF0; a <= 'hF3; a++) step(0, 0, 0, 1, a, 'h77, 0, "R8 setup");
    for (int i = 0; i < 4; i++) step(1, 1, 1023, 0, 0, 0, 0, "R8 no ramp");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule